// File: doc/BRIEF.md
# DMA Endpoint Write Width Adapter

This block sits on the write path from a DMA controller to the data registers of five USB device endpoints. A halfword-wide DMA path moves two bytes per beat, so a packet with an odd byte count would otherwise end with one byte too many. When software sets the enable bit of an endpoint, the adapter turns the final beat of an IN transfer to that endpoint into a single-byte write. The DMA controller marks that final beat with a last-transfer flag.

All other beats reach the endpoint at full width and unchanged. These are earlier beats, OUT-direction beats, beats to endpoints whose bit is clear, and beats to addresses that are not endpoint data registers. The enables sit in one 32-bit register. Software reads and writes it over a simple single-cycle access port. The write path is purely combinational, and each beat is classified on its own from the address, direction and last flag of that beat.

Top module: `wa_dma_ep_adapter`

## Requirements
- R1: After reset the enable register reads 0, so a last IN beat to any endpoint data register passes at full width.
- R2: The enable register holds written bits 4:0 and reads them back on `cfg_rdata[4:0]`. Bits 31:5 always read 0, whatever value was written to them.
- R3: Endpoint k (k = 1..5) has its data register at address 0x10 + 4*(k-1), and enable bit k-1 belongs to it. For an IN beat (`dma_in`=1) with `dma_last`=1 to that address, a set bit gives `ep_be`=2'b01 and `ep_data`={8'h00, `dma_data[7:0]`}.
- R4: A beat with `dma_last`=0 passes with `ep_be`=2'b11 and `ep_data`=`dma_data`, whatever the enables hold.
- R5: A beat with `dma_in`=0 (OUT direction) is never narrowed.
- R6: Only the enable bit of the addressed endpoint counts. With that bit clear, a last IN beat passes at full width even when every other bit is set.
- R7: A beat to an address that is no endpoint data register passes at full width. This includes misaligned addresses and addresses past endpoint 5.
- R8: `ep_valid` and `ep_addr` always equal `dma_valid` and `dma_addr`, and `ep_be` is 2'b00 whenever `dma_valid` is 0.
- R9: A register write in one cycle first affects beats in the following cycle. A beat in the same cycle as the write uses the old enable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Enable register write strobe |
| cfg_wdata | input | 32 | Enable register write data |
| cfg_rdata | output | 32 | Enable register read data |
| dma_valid | input | 1 | DMA write beat present |
| dma_addr | input | 8 | DMA destination address |
| dma_data | input | 16 | DMA write data |
| dma_in | input | 1 | 1 = IN direction (data into an endpoint) |
| dma_last | input | 1 | Last data item of the last packet |
| ep_valid | output | 1 | Endpoint write strobe |
| ep_addr | output | 8 | Endpoint register address |
| ep_data | output | 16 | Endpoint write data |
| ep_be | output | 2 | Byte-lane enables, bit 0 = low byte |

## Verification
A register write and a DMA beat can occur in the same cycle, and the beat must see the enable value from before the write. The bench sets up that cycle for a last IN beat to endpoint 3. It drives a write of all ones together with the beat and expects full lanes, then holds the beat one more cycle and expects the narrowed form. The bench also sweeps all 32 enable values against every endpoint address, several non-endpoint addresses, both directions and both last-flag values. It computes the expected lanes from the address arithmetic.

// File: rtl/wa_pkg.sv
package wa_pkg;
  localparam int unsigned REG_W = 32;

  function automatic logic [1:0] lane_mask(input logic valid, input logic narrow);
    if (!valid) return 2'b00;
    if (narrow) return 2'b01;
    return 2'b11;
  endfunction

  function automatic logic [15:0] shape_data(input logic narrow, input logic [15:0] d);
    return narrow ? {8'h00, d[7:0]} : d;
  endfunction
endpackage

// File: rtl/wa_cfg_reg.sv
module wa_cfg_reg #(
  parameter int NUM_EP = 5,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [NUM_EP-1:0] wdata,
  output logic [NUM_EP-1:0] en_q,
  output logic [REG_W-1:0]  rdata
);
  localparam int PAD_W = REG_W - NUM_EP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= '0;
    else if (wr) en_q <= wdata;
  end

  assign rdata = {{PAD_W{1'b0}}, en_q};
endmodule

// File: rtl/wa_ep_decode.sv
module wa_ep_decode #(
  parameter int                ADDR_W    = 8,
  parameter int                NUM_EP    = 5,
  parameter logic [ADDR_W-1:0] EP_BASE   = 8'h10,
  parameter int                EP_STRIDE = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_EP-1:0] hit
);
  for (genvar k = 0; k < NUM_EP; k++) begin : g_ep
    localparam logic [ADDR_W-1:0] EP_ADDR = EP_BASE + ADDR_W'(k * EP_STRIDE);
    assign hit[k] = (addr == EP_ADDR);
  end
endmodule

// File: rtl/wa_lane_shaper.sv
module wa_lane_shaper (
  input  logic        valid,
  input  logic        dir_in,
  input  logic        last,
  input  logic        sel_en,
  input  logic [15:0] din,
  output logic        narrow,
  output logic [1:0]  be,
  output logic [15:0] dout
);
  import wa_pkg::*;

  assign narrow = valid & dir_in & last & sel_en;
  assign be     = lane_mask(valid, narrow);
  assign dout   = shape_data(narrow, din);
endmodule

// File: rtl/wa_dma_ep_adapter.sv
module wa_dma_ep_adapter #(
  parameter int                ADDR_W    = 8,
  parameter int                NUM_EP    = 5,
  parameter logic [ADDR_W-1:0] EP_BASE   = 8'h10,
  parameter int                EP_STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              dma_valid,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [15:0]       dma_data,
  input  logic              dma_in,
  input  logic              dma_last,
  output logic              ep_valid,
  output logic [ADDR_W-1:0] ep_addr,
  output logic [15:0]       ep_data,
  output logic [1:0]        ep_be
);
  logic [NUM_EP-1:0] en_q;
  logic [NUM_EP-1:0] ep_hit;
  logic              sel_en;
  logic              narrow;
  logic              unused_hi;

  assign unused_hi = ^cfg_wdata[31:NUM_EP];

  wa_cfg_reg #(.NUM_EP(NUM_EP), .REG_W(32)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata[NUM_EP-1:0]),
    .en_q(en_q), .rdata(cfg_rdata)
  );

  wa_ep_decode #(.ADDR_W(ADDR_W), .NUM_EP(NUM_EP), .EP_BASE(EP_BASE),
                 .EP_STRIDE(EP_STRIDE)) u_dec (
    .addr(dma_addr), .hit(ep_hit)
  );

  assign sel_en = |(ep_hit & en_q);

  wa_lane_shaper u_shape (
    .valid(dma_valid), .dir_in(dma_in), .last(dma_last), .sel_en(sel_en),
    .din(dma_data), .narrow(narrow), .be(ep_be), .dout(ep_data)
  );

  assign ep_valid = dma_valid;
  assign ep_addr  = dma_addr;
endmodule

// File: rtl/wa_adapter_checker.sv
module wa_adapter_checker #(
  parameter int ADDR_W = 8,
  parameter int NUM_EP = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [31:0]       cfg_wdata,
  input logic [31:0]       cfg_rdata,
  input logic              dma_valid,
  input logic [15:0]       dma_data,
  input logic              dma_in,
  input logic              dma_last,
  input logic [15:0]       ep_data,
  input logic [1:0]        ep_be,
  input logic [NUM_EP-1:0] en_q,
  input logic [NUM_EP-1:0] ep_hit,
  input logic              narrow
);
  p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31:NUM_EP] == '0);

  p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_wr)) |-> cfg_rdata[NUM_EP-1:0] == $past(cfg_wdata[NUM_EP-1:0]));

  p_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && dma_in && dma_last && |(ep_hit & en_q))
      |-> (ep_be == 2'b01 && ep_data == {8'h00, dma_data[7:0]}));

  p_not_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && !dma_last) |-> (ep_be == 2'b11 && ep_data == dma_data));

  p_out_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && !dma_in) |-> ep_be == 2'b11);

  p_no_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && ep_hit == '0) |-> (ep_be == 2'b11 && !narrow));

  p_single_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ep_hit));

  p_idle_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_valid |-> ep_be == 2'b00);
endmodule

bind wa_dma_ep_adapter wa_adapter_checker #(.ADDR_W(ADDR_W), .NUM_EP(NUM_EP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .dma_valid(dma_valid), .dma_data(dma_data),
  .dma_in(dma_in), .dma_last(dma_last), .ep_data(ep_data), .ep_be(ep_be),
  .en_q(en_q), .ep_hit(ep_hit), .narrow(narrow)
);

// File: tb/tb_wa_dma_ep_adapter.sv
module tb_wa_dma_ep_adapter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_wr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic        dma_valid = 0;
  logic [7:0]  dma_addr = 0;
  logic [15:0] dma_data = 0;
  logic        dma_in = 0;
  logic        dma_last = 0;
  logic        ep_valid;
  logic [7:0]  ep_addr;
  logic [15:0] ep_data;
  logic [1:0]  ep_be;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wa_dma_ep_adapter dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .dma_valid(dma_valid), .dma_addr(dma_addr),
    .dma_data(dma_data), .dma_in(dma_in), .dma_last(dma_last),
    .ep_valid(ep_valid), .ep_addr(ep_addr), .ep_data(ep_data), .ep_be(ep_be)
  );

  // endpoint number 1..5 from address, 0 when none
  function automatic int ep_of(input logic [7:0] a);
    int off;
    off = int'(a) - 16;
    if (off < 0 || (off % 4) != 0 || (off / 4) > 4) return 0;
    return off / 4 + 1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic beat_check(input string req, input logic [4:0] en, input logic v,
                            input logic [7:0] a, input logic [15:0] d,
                            input logic di, input logic dl);
    int k;
    logic nar;
    logic [1:0] xbe;
    logic [15:0] xd;
    dma_valid = v; dma_addr = a; dma_data = d; dma_in = di; dma_last = dl;
    #1;
    k = ep_of(a);
    nar = v && di && dl && (k != 0) && en[k-1];
    xbe = !v ? 2'b00 : (nar ? 2'b01 : 2'b11);
    xd  = nar ? {8'h00, d[7:0]} : d;
    check({req, " be"}, 32'(ep_be), 32'(xbe));
    check({req, " data"}, 32'(ep_data), 32'(xd));
    check("R8 passthru", {23'h0, ep_valid, ep_addr}, {23'h0, v, a});
  endtask

  task automatic write_reg(input logic [31:0] w);
    @(negedge clk);
    cfg_wr = 1; cfg_wdata = w;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  initial begin
    logic [7:0] addrs [8];
    addrs = '{8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h11, 8'h24, 8'h0C};
    repeat (3) @(negedge clk);
    #1;
    check("R1 rdata after reset", cfg_rdata, 32'h0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 5; i++)
      beat_check("R1 reset no conversion", 5'h00, 1'b1, addrs[i], 16'hBEEF, 1'b1, 1'b1);

    for (int en = 0; en < 32; en++) begin
      logic [4:0] e;
      e = 5'(en);
      write_reg({~{27{e[0]}} ^ 27'h5A5A5A5, e});
      #1;
      check("R2 readback", cfg_rdata, {27'h0, e});
      for (int ai = 0; ai < 8; ai++)
        for (int m = 0; m < 4; m++) begin
          logic [15:0] d;
          string tag;
          d = 16'hC300 ^ {3'(ai), e, 8'h00} ^ 16'(8'h5B + 8'(en * 7 + ai));
          if (ai >= 5) tag = "R7 non-endpoint";
          else if (m[0] == 0) tag = "R4 not last";
          else if (m[1] == 0) tag = "R5 out dir";
          else tag = "R3/R6 last in";
          beat_check(tag, e, 1'b1, addrs[ai], d, m[1], m[0]);
        end
      beat_check("R8 idle", e, 1'b0, 8'h14, 16'h1234, 1'b1, 1'b1);
      @(negedge clk);
    end

    // R6: all bits except endpoint 4 set
    write_reg(32'h0000_0017);
    beat_check("R6 own bit clear", 5'h17, 1'b1, 8'h1C, 16'h77AB, 1'b1, 1'b1);
    beat_check("R6 other bit set", 5'h17, 1'b1, 8'h18, 16'h77AB, 1'b1, 1'b1);

    // R9: write and beat in the same cycle
    write_reg(32'h0);
    @(negedge clk);
    cfg_wr = 1; cfg_wdata = 32'hFFFF_FFFF;
    beat_check("R9 same-cycle old value", 5'h00, 1'b1, 8'h18, 16'hA5C3, 1'b1, 1'b1);
    @(negedge clk);
    cfg_wr = 0;
    beat_check("R9 next cycle new value", 5'h1F, 1'b1, 8'h18, 16'hA5C3, 1'b1, 1'b1);
    check("R2 pad after all-ones", cfg_rdata, 32'h0000_001F);
    dma_valid = 0;
    @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule